// File: doc/BRIEF.md
# Registry-Based Shared Word Directory

This block is the shared second-level storage controller for a group of private caches. Its word array does two jobs. Each word either holds the current value, or holds the number of the one core that has registered itself as the word's writer. No list of sharers exists anywhere. The only coherence state is a single state bit per word, plus an owner number that sits in the data bits of a registered word.

Each core presents one request at a time: a read, a registration or a writeback. A round-robin arbiter accepts one request per cycle, and the grant is raised in the same cycle as the request. A read of a held value is answered with the data. A registration takes the word over for the requester and is acknowledged. Writes never cause invalidation messages. A read of a registered word is answered with a forward that names the owner, so the owner's own copy can serve the read on the third hop. The owner gives the word back with a writeback that carries its data.

Top module: `reg_l2_dir`

## Requirements
- R1: After reset, every word holds the value 0. No response is valid and no grant is raised until a request arrives.
- R2: A read (op code 0, with op code 3 treated as a read) of a word that holds a value returns a response of kind 0 (data), with that value on rsp_data.
- R3: A registration (op code 1) marks the addressed word as registered to the requester. It returns a response of kind 1 (acknowledge), with rsp_owner equal to the requester. Other words are unchanged.
- R4: A read of a registered word returns a response of kind 2 (forward). rsp_owner holds the registered core, rsp_core holds the reader and rsp_data is 0.
- R5: A registration of a word already registered to another core replaces the owner. It produces only the single acknowledge to the new owner.
- R6: A writeback (op code 2) from the registered owner returns the word to holding a value, namely the written data. It is answered with kind 3 (writeback acknowledge).
- R7: A writeback from a core that is not the registered owner, or to a word that holds a value, changes nothing. It is still answered with kind 3.
- R8: At most one grant is raised per cycle, and only to a requesting core. The search starts at the core after the one granted last, wrapping around, and starts at core 0 after reset.
- R9: Each accepted request gives exactly one response, valid only in the cycle after acceptance. rsp_core equals the granted core and rsp_addr equals the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Request pending, one bit per core |
| req_op | input | 2*NCORES | Op code per core: 0 read, 1 register, 2 writeback, 3 read |
| req_addr | input | ADDR_W*NCORES | Word address per core |
| req_data | input | DATA_W*NCORES | Writeback data per core |
| req_ready | output | NCORES | One-hot grant; the request is taken at the clock edge |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 0 data, 1 acknowledge, 2 forward, 3 writeback acknowledge |
| rsp_core | output | ID_W | Core that made the request |
| rsp_owner | output | ID_W | Registered owner (forward, acknowledge), else 0 |
| rsp_addr | output | ADDR_W | Address of the request |
| rsp_data | output | DATA_W | Read data for kind 0, else 0 |

## Verification
The grant depends only on the current request bits and the arbiter pointer, so it is checked in the same cycle, after the inputs settle. A response and the update to a word both come from a single register stage. The response is checked one cycle after the grant, and the following cycle must show rsp_valid low again. A request accepted on the next cycle already sees the new word state, so each read that follows a registration or a writeback checks that update. The bench drives inputs and samples outputs on falling edges. In the contention tests it predicts the grant order from its own record of the last core it saw granted.

// File: rtl/reg_l2_dir.sv
module reg_l2_dir #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORES-1:0]        req_valid,
  input  logic [2*NCORES-1:0]      req_op,
  input  logic [ADDR_W*NCORES-1:0] req_addr,
  input  logic [DATA_W*NCORES-1:0] req_data,
  output logic [NCORES-1:0]        req_ready,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_kind,
  output logic [ID_W-1:0]          rsp_core,
  output logic [ID_W-1:0]          rsp_owner,
  output logic [ADDR_W-1:0]        rsp_addr,
  output logic [DATA_W-1:0]        rsp_data
);
  localparam logic [1:0] OP_RD = 2'd0, OP_REG = 2'd1, OP_WB = 2'd2;
  localparam logic [1:0] K_DATA = 2'd0, K_ACK = 2'd1, K_FWD = 2'd2, K_WBACK = 2'd3;

  logic [WORDS-1:0]  reg_q;
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [ID_W-1:0]   ptr_q, gidx;
  logic              gany;

  always_comb begin
    gany = 1'b0;
    gidx = '0;
    for (int i = 0; i < NCORES; i++) begin
      int k;
      k = (int'(ptr_q) + i) % NCORES;
      if (!gany && req_valid[k]) begin
        gany = 1'b1;
        gidx = ID_W'(k);
      end
    end
  end

  assign req_ready = gany ? (NCORES'(1) << gidx) : '0;

  logic [1:0]        g_op;
  logic [ADDR_W-1:0] g_addr;
  logic [DATA_W-1:0] g_data, e_pay;
  logic              e_reg;
  logic [ID_W-1:0]   e_own;

  assign g_op   = req_op[gidx*2 +: 2];
  assign g_addr = req_addr[gidx*ADDR_W +: ADDR_W];
  assign g_data = req_data[gidx*DATA_W +: DATA_W];
  assign e_reg  = reg_q[g_addr];
  assign e_pay  = mem_q[g_addr];
  assign e_own  = e_pay[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q     <= '0;
      ptr_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= K_DATA;
      rsp_core  <= '0;
      rsp_owner <= '0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (gany) begin
      ptr_q     <= (int'(gidx) == NCORES - 1) ? '0 : gidx + 1'b1;
      rsp_valid <= 1'b1;
      rsp_core  <= gidx;
      rsp_addr  <= g_addr;
      rsp_owner <= '0;
      rsp_data  <= '0;
      case (g_op)
        OP_REG: begin
          reg_q[g_addr] <= 1'b1;
          mem_q[g_addr] <= DATA_W'(gidx);
          rsp_kind      <= K_ACK;
          rsp_owner     <= gidx;
        end
        OP_WB: begin
          rsp_kind <= K_WBACK;
          if (e_reg && e_own == gidx) begin
            reg_q[g_addr] <= 1'b0;
            mem_q[g_addr] <= g_data;
          end
        end
        default: begin
          if (e_reg) begin
            rsp_kind  <= K_FWD;
            rsp_owner <= e_own;
          end else begin
            rsp_kind <= K_DATA;
            rsp_data <= e_pay;
          end
        end
      endcase
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

module reg_l2_dir_chk #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCORES-1:0]        req_valid,
  input logic [2*NCORES-1:0]      req_op,
  input logic [NCORES-1:0]        req_ready,
  input logic                     rsp_valid,
  input logic [1:0]               rsp_kind,
  input logic [ID_W-1:0]          rsp_core,
  input logic [ID_W-1:0]          rsp_owner,
  input logic [DATA_W-1:0]        rsp_data
);
  logic [ID_W-1:0] gi;
  logic [1:0]      gop;
  always_comb begin
    gi = '0;
    for (int i = 0; i < NCORES; i++) if (req_ready[i]) gi = ID_W'(i);
    gop = req_op[gi*2 +: 2];
  end

  a_r8_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  a_r9_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> rsp_valid);
  a_r9_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> !rsp_valid);
  a_r9_rsp_core: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> rsp_core == $past(gi));
  a_r3_ack_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_ready) && gop == 2'd1) |=> (rsp_kind == 2'd1 && rsp_owner == $past(gi)));
  a_r4_fwd_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> rsp_data == '0);
endmodule

bind reg_l2_dir reg_l2_dir_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (.*);

// File: tb/tb_reg_l2_dir.sv
`timescale 1ns/1ps
module tb_reg_l2_dir;
  localparam int NC = 4, AW = 4, DW = 16, IW = 2;
  logic clk = 0, rst_n = 0;
  logic [NC-1:0] req_valid = '0;
  logic [2*NC-1:0] req_op = '0;
  logic [AW*NC-1:0] req_addr = '0;
  logic [DW*NC-1:0] req_data = '0;
  logic [NC-1:0] req_ready;
  logic rsp_valid;
  logic [1:0] rsp_kind;
  logic [IW-1:0] rsp_core, rsp_owner;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;
  int n_chk = 0, n_bad = 0, exp_ptr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reg_l2_dir dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic set_req(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid[c] = 1'b1;
    req_op[c*2 +: 2] = op;
    req_addr[c*AW +: AW] = a;
    req_data[c*DW +: DW] = d;
  endtask

  task automatic issue(string tag, int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [1:0] ek, int eo, logic [DW-1:0] ed);
    @(negedge clk);
    set_req(c, op, a, d);
    #1;
    chk({tag, " R8 grant"}, 32'(req_ready), 32'(1 << c));
    @(negedge clk);
    req_valid = '0;
    chk({tag, " R9 rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " R9 rsp_core"}, 32'(rsp_core), 32'(c));
    chk({tag, " R9 rsp_addr"}, 32'(rsp_addr), 32'(a));
    chk({tag, " kind"}, 32'(rsp_kind), 32'(ek));
    chk({tag, " owner"}, 32'(rsp_owner), 32'(eo));
    chk({tag, " data"}, 32'(rsp_data), 32'(ed));
    exp_ptr = (c + 1) % NC;
    @(negedge clk);
    chk({tag, " R9 single response"}, 32'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R1 no grant after reset", 32'(req_ready), 0);
    issue("R1 initial word 9", 2, 2'd0, 4'd9, '0, 2'd0, 0, 16'h0);
  endtask

  task automatic t_register_forward();
    issue("R3 register c1", 1, 2'd1, 4'd3, '0, 2'd1, 1, 16'h0);
    issue("R4 forward to c1", 2, 2'd0, 4'd3, '0, 2'd2, 1, 16'h0);
    issue("R3 neighbour untouched", 2, 2'd0, 4'd4, '0, 2'd0, 0, 16'h0);
    issue("R5 re-register c0", 0, 2'd1, 4'd3, '0, 2'd1, 0, 16'h0);
    issue("R5 forward to c0", 3, 2'd3, 4'd3, '0, 2'd2, 0, 16'h0);
  endtask

  task automatic t_writeback();
    issue("R7 non-owner wb", 1, 2'd2, 4'd3, 16'hBEEF, 2'd3, 0, 16'h0);
    issue("R7 still owned c0", 2, 2'd0, 4'd3, '0, 2'd2, 0, 16'h0);
    issue("R6 owner wb", 0, 2'd2, 4'd3, 16'h1234, 2'd3, 0, 16'h0);
    issue("R2 read back data", 2, 2'd0, 4'd3, '0, 2'd0, 0, 16'h1234);
    issue("R7 wb to valid word", 2, 2'd2, 4'd7, 16'h5555, 2'd3, 0, 16'h0);
    issue("R7 valid word kept", 1, 2'd0, 4'd7, '0, 2'd0, 0, 16'h0);
  endtask

  task automatic contend(string tag, logic [NC-1:0] who);
    logic [NC-1:0] left;
    int ord[$];
    left = who;
    for (int i = 0; i < NC; i++) begin
      int k;
      k = (exp_ptr + i) % NC;
      if (who[k]) ord.push_back(k);
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) if (who[c]) set_req(c, 2'd0, 4'd3, '0);
    foreach (ord[j]) begin
      #1;
      chk({tag, " R8 grant order"}, 32'(req_ready), 32'(1 << ord[j]));
      @(negedge clk);
      chk({tag, " R9 rsp_core"}, 32'(rsp_core), 32'(ord[j]));
      chk({tag, " R2 data"}, 32'(rsp_data), 32'h1234);
      req_valid[ord[j]] = 1'b0;
      left[ord[j]] = 1'b0;
      exp_ptr = (ord[j] + 1) % NC;
    end
    #1;
    chk({tag, " R8 no grant left"}, 32'(req_ready), 0);
    @(negedge clk);
    chk({tag, " R9 idle"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_register_forward();
    t_writeback();
    contend("all four", 4'b1111);
    contend("cores 0 and 2", 4'b0101);
    contend("cores 1 and 3", 4'b1010);
    finish_run();
  end
endmodule